// File: doc/BRIEF.md
# Bridge Reset Handshake Sequencer

This block takes a bridge, which sits between fabric-side masters and a memory controller, through a safe reset cycle. A controller starts it with a single-cycle pulse. If the warning-enable bit is set, the sequencer first asks the fabric logic to go quiet and waits for its acknowledge. It then always asks the bridge to fence and drain outstanding traffic. Once the drain is confirmed, it holds the bridge in reset until reconfiguration reports done.

After reconfiguration completes, the sequencer undoes its work in a fixed order: bridge reset first, then the fabric warning request, then the flush request. It then waits for the flush acknowledge to fall, followed by the fabric acknowledge (the latter only if the warning stage ran). Finally it pulses done.

Every acknowledge input and the reconfiguration-done input pass through two-flop synchronizers. Every acknowledge wait is bounded by a programmable cycle count. When a wait runs out, the sequencer sets a sticky timeout flag, withdraws both requests, leaves the bridge in reset and returns to idle.

States: IDLE, WARN_REQ, WARN_WAIT, FLUSH_REQ, FLUSH_WAIT, IN_RESET, RELEASE, CLEAR_REQ, WAIT_ACK_LOW, DONE. Transitions:

| From | Condition | To |
|------|-----------|----|
| IDLE | start with warning enabled | WARN_REQ |
| IDLE | start with warning disabled | FLUSH_REQ |
| WARN_REQ | always | WARN_WAIT |
| WARN_WAIT | fabric acknowledge seen | FLUSH_REQ |
| WARN_WAIT | timeout | IDLE |
| FLUSH_REQ | always | FLUSH_WAIT |
| FLUSH_WAIT | flush acknowledge seen | IN_RESET |
| FLUSH_WAIT | timeout | IDLE |
| IN_RESET | reconfiguration done | RELEASE |
| RELEASE | always | CLEAR_REQ |
| CLEAR_REQ | always | WAIT_ACK_LOW |
| WAIT_ACK_LOW | required acknowledges low | DONE |
| WAIT_ACK_LOW | timeout | IDLE |
| DONE | always | IDLE |

Top module: `bridge_rst_seq`

## Requirements
- R1: After reset, all outputs are low: both requests, bridge_rst_o, busy_o, done_o and timeout_o.
- R2: With warn_en_i = 1 at start, warn_req_o rises, and flush_req_o rises only after warn_ack_i has been high.
- R3: With warn_en_i = 0 at start, warn_req_o stays low for the whole sequence and flush_req_o is raised directly.
- R4: bridge_rst_o rises inside a sequence only after flush_ack_i has been seen high, and flush_req_o is still high when it does.
- R5: bridge_rst_o stays high until reconf_done_i is asserted, and falls only while reconf_done_i is high.
- R6: On release, bridge_rst_o falls first, then warn_req_o, then flush_req_o, each in a strictly later cycle than the one before.
- R7: done_o is a one-cycle pulse. It is raised only when flush_ack_i is low and, if the warning stage ran, warn_ack_i is low as well. When the warning stage was skipped, the level of warn_ack_i has no effect.
- R8: If an acknowledge wait lasts more than timeout_limit_i cycles, the sequencer sets timeout_o, returns to idle with both requests low, leaves bridge_rst_o high and does not pulse done.
- R9: A start pulse that arrives while busy_o is high is ignored: exactly one done pulse follows, and no second sequence starts afterwards.
- R10: timeout_o stays high until the next accepted start, which clears it.
- R11: busy_o rises only in the cycle after an accepted start, and stays high until the DONE state or a timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; honoured only when idle |
| warn_en_i | input | 1 | Enables the fabric warning stage |
| timeout_limit_i | input | TO_W | Cycle limit for each acknowledge wait |
| warn_ack_i | input | 1 | Fabric warning acknowledge (asynchronous) |
| flush_ack_i | input | 1 | Bridge flush acknowledge (asynchronous) |
| reconf_done_i | input | 1 | Reconfiguration complete (asynchronous) |
| warn_req_o | output | 1 | Fabric warning request |
| flush_req_o | output | 1 | Bridge fence-and-drain request |
| bridge_rst_o | output | 1 | Bridge reset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky acknowledge timeout flag |

## Verification
Two functions can coincide: a new start pulse and an in-flight sequence, including the single DONE cycle in which the sequencer is about to return to idle. The bench fires extra start pulses at random points while busy_o is high and requires exactly one done pulse, followed by busy_o staying low. The second collision is a pending acknowledge wait against timeout expiry. Holding an acknowledge at the wrong level makes the expiry win, which is judged by timeout_o, bridge_rst_o and both requests. Prompt acknowledges are judged by a clean completion with timeout_o low.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WARN_REQ,
        ST_WARN_WAIT,
        ST_FLUSH_REQ,
        ST_FLUSH_WAIT,
        ST_IN_RESET,
        ST_RELEASE,
        ST_CLEAR_REQ,
        ST_WAIT_ACK_LOW,
        ST_DONE
    } brs_state_e;

    localparam int unsigned BRS_SYNC_STAGES = 2;

endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[g] <= '0;
                end else if (g == 0) begin
                    pipe_q[g] <= d_i;
                end else begin
                    pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/brs_wait_timer.sv
module brs_wait_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != limit_i)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == limit_i);

endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
    import brs_pkg::*;
#(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            warn_en_i,
    input  logic [TO_W-1:0] timeout_limit_i,
    input  logic            warn_ack_i,
    input  logic            flush_ack_i,
    input  logic            reconf_done_i,
    output logic            warn_req_o,
    output logic            flush_req_o,
    output logic            bridge_rst_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            timeout_o
);

    localparam int unsigned NSYNC = 3;

    brs_state_e       state_q, state_d;
    logic [NSYNC-1:0] raw_in, syn_in;
    logic             warn_ack_s, flush_ack_s, reconf_s;
    logic             warn_used_q;
    logic             phase_warn_q;
    logic             phase_step;
    logic             abort;
    logic             accept;
    logic             in_wait;
    logic             tmr_clr, tmr_exp;

    // Synchronise every input that may come from another clock domain
    assign raw_in = {reconf_done_i, flush_ack_i, warn_ack_i};

    brs_sync #(.WIDTH(NSYNC), .STAGES(BRS_SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign warn_ack_s  = syn_in[0];
    assign flush_ack_s = syn_in[1];
    assign reconf_s    = syn_in[2];

    assign in_wait = (state_q == ST_WARN_WAIT) || (state_q == ST_FLUSH_WAIT) ||
                     (state_q == ST_WAIT_ACK_LOW);

    assign accept = (state_q == ST_IDLE) && start_i;

    // In the low-acknowledge wait, move from the flush phase to the fabric phase
    assign phase_step = (state_q == ST_WAIT_ACK_LOW) && !phase_warn_q &&
                        !flush_ack_s && warn_used_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = warn_en_i ? ST_WARN_REQ : ST_FLUSH_REQ;
            ST_WARN_REQ:   state_d = ST_WARN_WAIT;
            ST_WARN_WAIT: begin
                if (warn_ack_s)   state_d = ST_FLUSH_REQ;
                else if (tmr_exp) state_d = ST_IDLE;
            end
            ST_FLUSH_REQ:  state_d = ST_FLUSH_WAIT;
            ST_FLUSH_WAIT: begin
                if (flush_ack_s)  state_d = ST_IN_RESET;
                else if (tmr_exp) state_d = ST_IDLE;
            end
            ST_IN_RESET:   if (reconf_s) state_d = ST_RELEASE;
            ST_RELEASE:    state_d = ST_CLEAR_REQ;
            ST_CLEAR_REQ:  state_d = ST_WAIT_ACK_LOW;
            ST_WAIT_ACK_LOW: begin
                if ((!phase_warn_q && !flush_ack_s && !warn_used_q) ||
                    (phase_warn_q && !warn_ack_s))
                    state_d = ST_DONE;
                else if (tmr_exp && !phase_step)
                    state_d = ST_IDLE;
            end
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign abort = in_wait && (state_d == ST_IDLE);

    // Restart the wait timer on every state change or phase change
    assign tmr_clr = !in_wait || (state_d != state_q) || phase_step;

    brs_wait_timer #(.CW(TO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (in_wait),
        .limit_i   (timeout_limit_i),
        .expired_o (tmr_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and per-sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_req_o   <= 1'b0;
            flush_req_o  <= 1'b0;
            bridge_rst_o <= 1'b0;
            timeout_o    <= 1'b0;
            warn_used_q  <= 1'b0;
            phase_warn_q <= 1'b0;
        end else if (abort) begin
            warn_req_o   <= 1'b0;
            flush_req_o  <= 1'b0;
            bridge_rst_o <= 1'b1;
            timeout_o    <= 1'b1;
        end else begin
            if (accept) begin
                timeout_o    <= 1'b0;
                warn_used_q  <= warn_en_i;
                phase_warn_q <= 1'b0;
            end
            if (phase_step) phase_warn_q <= 1'b1;
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_WARN_REQ:     warn_req_o   <= 1'b1;
                    ST_FLUSH_REQ:    flush_req_o  <= 1'b1;
                    ST_IN_RESET:     bridge_rst_o <= 1'b1;
                    ST_RELEASE:      bridge_rst_o <= 1'b0;
                    ST_CLEAR_REQ:    warn_req_o   <= 1'b0;
                    ST_WAIT_ACK_LOW: flush_req_o  <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/brs_checker.sv
module brs_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic warn_req_o,
    input logic flush_req_o,
    input logic bridge_rst_o,
    input logic timeout_o
);

    assert_rst_flushed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bridge_rst_o) && busy_o) |-> flush_req_o);

    assert_warn_drop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(warn_req_o) && busy_o) |-> (flush_req_o && !bridge_rst_o));

    assert_flush_drop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flush_req_o) && busy_o) |-> (!warn_req_o && !bridge_rst_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!warn_req_o && !flush_req_o && !bridge_rst_o && !timeout_o));

    assert_timeout_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (bridge_rst_o && !busy_o && !warn_req_o && !flush_req_o));

    assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_o) |-> $past(start_i));

endmodule

bind bridge_rst_seq brs_checker u_brs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .warn_req_o   (warn_req_o),
    .flush_req_o  (flush_req_o),
    .bridge_rst_o (bridge_rst_o),
    .timeout_o    (timeout_o)
);

// File: tb/bridge_rst_seq_test.sv
module bridge_rst_seq_test;

    localparam int unsigned TO_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            warn_en_i = 1'b0;
    logic [TO_W-1:0] timeout_limit_i = 16'd200;
    logic            warn_ack_i = 1'b0;
    logic            flush_ack_i = 1'b0;
    logic            reconf_done_i = 1'b0;
    logic            warn_req_o, flush_req_o, bridge_rst_o, busy_o, done_o, timeout_o;

    int checks = 0;
    int fails  = 0;

    // responder controls
    bit warn_auto = 1, flush_auto = 1, flush_drop = 1, reconf_auto = 1;
    bit exp_warn  = 0;
    bit noise_start = 0;
    int wcnt = 3, fcnt = 3, rcnt = 3;
    // monitor state
    bit warn_ack_seen = 0, flush_ack_seen = 0;
    bit p_rst = 0, p_wreq = 0, p_freq = 0, p_done = 0;
    int err_r2 = 0, err_r3 = 0, err_r4 = 0, err_r5 = 0, err_r6 = 0, err_r7 = 0;
    int done_cnt = 0;

    bridge_rst_seq #(.TO_W(TO_W)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .warn_en_i       (warn_en_i),
        .timeout_limit_i (timeout_limit_i),
        .warn_ack_i      (warn_ack_i),
        .flush_ack_i     (flush_ack_i),
        .reconf_done_i   (reconf_done_i),
        .warn_req_o      (warn_req_o),
        .flush_req_o     (flush_req_o),
        .bridge_rst_o    (bridge_rst_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .timeout_o       (timeout_o)
    );

    initial forever #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected done eligibility from the bench's own acknowledge levels
    function automatic bit done_allowed(input bit fack, input bit wack, input bit used);
        return !fack && (!used || !wack);
    endfunction

    // Monitor and fabric/bridge responder, both at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (warn_ack_i) warn_ack_seen = 1;
            if (flush_ack_i && flush_req_o) flush_ack_seen = 1;
            if (warn_req_o && !exp_warn) err_r3++;
            if (flush_req_o && !p_freq && exp_warn && !warn_ack_seen) err_r2++;
            if (bridge_rst_o && !p_rst && busy_o && (!flush_ack_seen || !flush_req_o)) err_r4++;
            if (!bridge_rst_o && p_rst && busy_o && !reconf_done_i) err_r5++;
            if (!warn_req_o && p_wreq && busy_o && (bridge_rst_o || !flush_req_o)) err_r6++;
            if (!flush_req_o && p_freq && busy_o && (warn_req_o || bridge_rst_o)) err_r6++;
            if (done_o) begin
                done_cnt++;
                if (p_done || !done_allowed(flush_ack_i, warn_ack_i, exp_warn)) err_r7++;
            end
            p_rst = bridge_rst_o; p_wreq = warn_req_o; p_freq = flush_req_o; p_done = done_o;
            // responder
            if (warn_auto) begin
                if (warn_req_o != warn_ack_i) begin
                    if (wcnt == 0) begin warn_ack_i = warn_req_o; wcnt = $urandom_range(0, 12); end
                    else wcnt--;
                end
            end
            if (flush_auto) begin
                if (flush_req_o && !flush_ack_i) begin
                    if (fcnt == 0) begin flush_ack_i = 1; fcnt = $urandom_range(0, 12); end
                    else fcnt--;
                end else if (!flush_req_o && flush_ack_i && flush_drop) begin
                    if (fcnt == 0) begin flush_ack_i = 0; fcnt = $urandom_range(0, 12); end
                    else fcnt--;
                end
            end
            if (reconf_auto) begin
                if (bridge_rst_o && busy_o && !reconf_done_i) begin
                    if (rcnt == 0) begin reconf_done_i = 1; rcnt = $urandom_range(0, 20); end
                    else rcnt--;
                end else if (!bridge_rst_o) reconf_done_i = 0;
            end
            if (noise_start && busy_o && ($urandom_range(0, 3) == 0)) start_i = 1;
            else if (noise_start) start_i = 0;
        end
    end

    task automatic clear_mon(input bit wen);
        exp_warn = wen; warn_ack_seen = 0; flush_ack_seen = 0; done_cnt = 0;
        err_r2 = 0; err_r3 = 0; err_r4 = 0; err_r5 = 0; err_r6 = 0; err_r7 = 0;
    endtask

    task automatic pulse_start(input bit wen);
        @(negedge clk);
        warn_en_i = wen; start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    // Full sequence expected to complete normally
    task automatic run_seq(input bit wen, input bit noisy);
        int n;
        clear_mon(wen);
        pulse_start(wen);
        @(negedge clk);
        check(busy_o && !timeout_o, "R11/R10 busy after start", busy_o, 1);
        noise_start = noisy;
        n = 0;
        while (done_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
        noise_start = 0; start_i = 0;
        repeat (20) @(negedge clk);
        check(done_cnt == 1, noisy ? "R9 single done" : "R7 done count", done_cnt, 1);
        check(!busy_o && !bridge_rst_o && !timeout_o, "R5 bridge released, idle", bridge_rst_o, 0);
        check(err_r2 == 0, "R2 flush after warn ack", err_r2, 0);
        check(err_r3 == 0, "R3 warn skipped", err_r3, 0);
        check(err_r4 == 0, "R4 reset after flush ack", err_r4, 0);
        check(err_r5 == 0, "R5 release after reconf", err_r5, 0);
        check(err_r6 == 0, "R6 release order", err_r6, 0);
        check(err_r7 == 0, "R7 done conditions", err_r7, 0);
    endtask

    task automatic expect_timeout(input string tag);
        repeat (3 * int'(timeout_limit_i) + 150) @(negedge clk);
        check(timeout_o == 1, {tag, " timeout flag"}, timeout_o, 1);
        check(bridge_rst_o == 1, {tag, " reset held"}, bridge_rst_o, 1);
        check(!busy_o && !warn_req_o && !flush_req_o, {tag, " idle, requests low"},
              {busy_o, warn_req_o, flush_req_o}, 0);
        check(done_cnt == 0, {tag, " no done"}, done_cnt, 0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        check({warn_req_o, flush_req_o, bridge_rst_o, busy_o, done_o, timeout_o} == 6'b0,
              "R1 reset state", {warn_req_o, flush_req_o, bridge_rst_o, busy_o, done_o, timeout_o}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        run_seq(1, 0);  // R2 R4 R5 R6 R7
        run_seq(0, 0);  // R3

        // R7: skipped warning, fabric acknowledge stuck high has no effect
        warn_auto = 0; warn_ack_i = 1;
        run_seq(0, 0);
        warn_ack_i = 0; warn_auto = 1;

        run_seq(1, 1);  // R9 start pulses while busy

        // R8: fabric never acknowledges
        timeout_limit_i = 16'd20;
        warn_auto = 0; warn_ack_i = 0;
        clear_mon(1); pulse_start(1);
        expect_timeout("R8 warn wait");
        warn_auto = 1;
        run_seq(1, 0);  // R10: cleared by next start

        // R8: bridge never drains
        flush_auto = 0;
        clear_mon(0); pulse_start(0);
        expect_timeout("R8 flush wait");
        flush_auto = 1;
        check(timeout_o == 1, "R10 flag sticky while idle", timeout_o, 1);
        run_seq(0, 0);

        // R8: flush acknowledge never returns low
        flush_drop = 0;
        clear_mon(1); pulse_start(1);
        expect_timeout("R8 ack-low wait");
        flush_ack_i = 0; flush_drop = 1;
        timeout_limit_i = 16'd200;
        run_seq(1, 0);

        for (int i = 0; i < 12; i++) begin
            run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule